// File: doc/BRIEF.md
# Integer Execute Stage with Immediates

This block is the integer execute step of a 32-bit pipeline. Each cycle it may accept one operation. The operation takes two register operands, or one register operand plus a 16-bit immediate, together with a 4-bit operation code. The block returns the 32-bit result, an overflow-exception flag and a destination write-enable. All three are registered one clock after the operation is presented.

The block widens the immediate according to the operation. Logic forms widen it with zeros. Arithmetic forms widen it with copies of its sign bit, and this includes the unsigned add form. Only the trapping arithmetic forms raise the overflow flag. When they do, the write-enable drops so that the destination register keeps its old value. The block has no state machine: its only state is one output register stage, and that stage is reloaded from the operation inputs on every cycle where `in_valid` is high.

Top module: `int_exec_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `wr_en`, `ovf` and `result` are all 0.
- R2: When `in_valid` is high at a rising clock edge, the outputs for that operation appear right after that edge. When `in_valid` is low, `out_valid`, `wr_en` and `ovf` are 0 after the edge and `result` keeps its previous value.
- R3: Codes ADD=0, ADDU=1, SUB=2 and SUBU=3 return `src_a + src_b` (ADD, ADDU) or `src_a - src_b` (SUB, SUBU), modulo 2^32.
- R4: Codes ADDI=4 and ADDIU=5 add `src_a` to the sign-extended `imm`. For example, 0 plus imm 0xFFFF gives 0xFFFFFFFF.
- R5: Codes ANDI=10, ORI=11 and XORI=12 combine `src_a` with the zero-extended `imm`.
- R6: Codes AND=6, OR=7, XOR=8 and NOR=9 return the bitwise AND, OR, XOR and NOR of `src_a` and `src_b`.
- R7: Code LUI=15 returns `imm` in bits 31:16 and zeros in bits 15:0.
- R8: Code SLT=13 returns 1 if `src_a` is less than `src_b`, compared as signed two's-complement values, and 0 otherwise. Code SLTI=14 does the same against the sign-extended `imm`. Bits 31:1 of the result are always 0.
- R9: `ovf` can be set only by ADD, SUB and ADDI, and only when the true signed result does not fit in 32 bits. All other codes never set it.
- R10: For a valid operation, `wr_en` is 1 exactly when `ovf` is 0. When `ovf` is 1, `result` still holds the wrapped value.
- R11: Register forms ignore `imm`. Immediate forms and LUI ignore `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R3 to R8) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate constant |
| out_valid | output | 1 | Registered copy of `in_valid` |
| result | output | 32 | Registered result |
| ovf | output | 1 | Overflow exception for the registered operation |
| wr_en | output | 1 | Destination write-enable for the registered operation |

## Verification
Every result, flag and write-enable is due one rising edge after the operation is presented, because a single register stage sits on the path. The bench applies inputs on the falling edge and reads the outputs on the next falling edge, so it samples exactly one edge later. It computes the expected value from a behavioural model that uses wider signed arithmetic. Idle cycles are read the same way to confirm that the flags clear and the result is held. The bench covers directed corner cases (signed limits, sign-bit immediates, opposite-sign compares) and then runs a long stretch of random operations.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDU  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBU  = 4'd3,
        OP_ADDI  = 4'd4,
        OP_ADDIU = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_NOR   = 4'd9,
        OP_ANDI  = 4'd10,
        OP_ORI   = 4'd11,
        OP_XORI  = 4'd12,
        OP_SLT   = 4'd13,
        OP_SLTI  = 4'd14,
        OP_LUI   = 4'd15
    } exec_op_e;

    // Operation codes that may raise the overflow exception.
    function automatic logic op_traps(exec_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
    endfunction

    // Operation codes whose result is a single comparison bit.
    function automatic logic op_compares(exec_op_e op);
        return (op == OP_SLT) || (op == OP_SLTI);
    endfunction

endpackage

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  exec_op_e            op,
    input  logic [DATA_W-1:0]   reg_b,
    input  logic [IMM_W-1:0]    imm,
    output logic [DATA_W-1:0]   opnd_b
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;
    logic [DATA_W-1:0] imm_high;

    assign imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign imm_zext = {{PAD_W{1'b0}}, imm};
    assign imm_high = {imm, {PAD_W{1'b0}}};

    always_comb begin
        opnd_b = reg_b;
        unique case (op)
            OP_ADDI, OP_ADDIU, OP_SLTI: opnd_b = imm_sext;
            OP_ANDI, OP_ORI, OP_XORI:   opnd_b = imm_zext;
            OP_LUI:                     opnd_b = imm_high;
            default:                    opnd_b = reg_b;
        endcase
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  exec_op_e            op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output logic                ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;
    logic              add_ovf;
    logic              sub_ovf;
    logic              lt_signed;

    assign sum  = a + b;
    assign diff = a - b;

    // Same-sign addends with a flipped result sign.
    assign add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    // Subtrahend sign is inverted before the same test.
    assign sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

    assign lt_signed = $signed(a) < $signed(b);

    always_comb begin
        res = '0;
        ovf = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDI: begin
                res = sum;
                ovf = add_ovf;
            end
            OP_ADDU, OP_ADDIU:       res = sum;
            OP_SUB: begin
                res = diff;
                ovf = sub_ovf;
            end
            OP_SUBU:                 res = diff;
            OP_AND, OP_ANDI:         res = a & b;
            OP_OR, OP_ORI:           res = a | b;
            OP_XOR, OP_XORI:         res = a ^ b;
            OP_NOR:                  res = ~(a | b);
            OP_SLT, OP_SLTI:         res = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_LUI:                  res = b;
            default:                 res = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3:0]          op,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [IMM_W-1:0]    imm,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                ovf,
    output logic                wr_en
);

    exec_op_e          op_e;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic              alu_ovf;

    assign op_e = exec_op_e'(op);

    exec_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opsel (
        .op     (op_e),
        .reg_b  (src_b),
        .imm    (imm),
        .opnd_b (opnd_b)
    );

    exec_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op  (op_e),
        .a   (src_a),
        .b   (opnd_b),
        .res (alu_res),
        .ovf (alu_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ovf       <= in_valid & alu_ovf;
            wr_en     <= in_valid & ~alu_ovf;
            if (in_valid) begin
                result <= alu_res;
            end
        end
    end

    // R2: an accepted operation is reported one edge later.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle cycles clear the flags and hold the result.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !ovf && $stable(result)));

    // R10: an exception and a write never coincide.
    p_ovf_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (!wr_en && out_valid));

    // R9: non-trapping codes never raise the exception.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_traps(op_e)) |=> !ovf);

    // R7: the low half after LUI is zero.
    p_lui_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_LUI) |=> (result[DATA_W-IMM_W-1:0] == '0));

    // R8: comparisons return a single bit.
    p_slt_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_compares(op_e)) |=> (result[DATA_W-1:1] == '0));

endmodule

// File: tb/sim_int_exec_stage.sv
`timescale 1ns/1ps
module sim_int_exec_stage;

    localparam int DW = 32;
    localparam int WATCHDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    op = '0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic [15:0]   imm = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          ovf;
    logic          wr_en;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] last_res = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    int_exec_stage u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm       (imm),
        .out_valid (out_valid),
        .result    (result),
        .ovf       (ovf),
        .wr_en     (wr_en)
    );

    function automatic void model(input logic [3:0] c, input logic [31:0] a,
                                  input logic [31:0] b, input logic [15:0] k,
                                  output logic [31:0] r, output logic v);
        longint sa, sb, sk, wide;
        logic [31:0] kz;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        sk = longint'($signed(k));
        kz = {16'h0, k};
        v = 1'b0;
        wide = 0;
        case (c)
            0:  begin wide = sa + sb; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            1:  wide = sa + sb;
            2:  begin wide = sa - sb; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            3:  wide = sa - sb;
            4:  begin wide = sa + sk; v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            5:  wide = sa + sk;
            6:  wide = longint'(a & b);
            7:  wide = longint'(a | b);
            8:  wide = longint'(a ^ b);
            9:  wide = longint'(~(a | b));
            10: wide = longint'(a & kz);
            11: wide = longint'(a | kz);
            12: wide = longint'(a ^ kz);
            13: wide = (sa < sb) ? 1 : 0;
            14: wide = (sa < sk) ? 1 : 0;
            default: wide = longint'(k) * 65536;
        endcase
        r = wide[31:0];
    endfunction

    task automatic run_op(input string tag, input logic [3:0] c, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] k);
        logic [31:0] er;
        logic ev;
        model(c, a, b, k, er, ev);
        in_valid = 1'b1; op = c; src_a = a; src_b = b; imm = k;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (result !== er || ovf !== ev || wr_en !== !ev || out_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s op=%0d: result=%h ovf=%b wr_en=%b valid=%b expected result=%h ovf=%b wr_en=%b valid=1",
                     tag, c, result, ovf, wr_en, out_valid, er, ev, !ev);
        end
        last_res = er;
    endtask

    task automatic idle_check();
        in_valid = 1'b0; op = 4'($urandom); src_a = $urandom; src_b = $urandom; imm = 16'($urandom);
        @(negedge clk);
        checks++;
        if (result !== last_res || ovf !== 1'b0 || wr_en !== 1'b0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle: result=%h ovf=%b wr_en=%b valid=%b expected result=%h ovf=0 wr_en=0 valid=0",
                     result, ovf, wr_en, out_valid, last_res);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || ovf !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R1 reset: valid=%b wr_en=%b ovf=%b result=%h expected all zero",
                     out_valid, wr_en, ovf, result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R3 add",          4'd0,  32'd100,        32'd23,         16'h0);
        run_op("R9 add ovf R10",  4'd0,  32'h7FFFFFFF,   32'd1,          16'h0);
        run_op("R9 addu no ovf",  4'd1,  32'h7FFFFFFF,   32'd1,          16'h0);
        run_op("R9 add neg ovf",  4'd0,  32'h80000000,   32'hFFFFFFFF,   16'h0);
        run_op("R9 sub ovf R10",  4'd2,  32'h80000000,   32'd1,          16'h0);
        run_op("R3 sub",          4'd2,  32'd5,          32'd9,          16'h0);
        run_op("R3 subu",         4'd3,  32'h80000000,   32'd1,          16'h0);
        run_op("R4 addiu -1",     4'd5,  32'd0,          32'h12345678,   16'hFFFF);
        run_op("R4 addi neg",     4'd4,  32'd10,         32'd0,          16'hFFF0);
        run_op("R9 addi ovf",     4'd4,  32'h7FFFFFFF,   32'd0,          16'h0001);
        run_op("R5 andi zext",    4'd10, 32'hFFFFFFFF,   32'd0,          16'h8001);
        run_op("R5 ori zext",     4'd11, 32'h00000000,   32'hFFFFFFFF,   16'h8000);
        run_op("R5 xori zext",    4'd12, 32'hF0F0F0F0,   32'd0,          16'hFFFF);
        run_op("R6 and",          4'd6,  32'hFF00FF00,   32'h0FF00FF0,   16'hFFFF);
        run_op("R6 or",           4'd7,  32'hFF00FF00,   32'h0FF00FF0,   16'h0);
        run_op("R6 xor",          4'd8,  32'hFF00FF00,   32'h0FF00FF0,   16'h0);
        run_op("R6 nor",          4'd9,  32'hFF00FF00,   32'h0FF00FF0,   16'h0);
        run_op("R7 lui",          4'd15, 32'hDEADBEEF,   32'hCAFEF00D,   16'h1234);
        run_op("R8 slt neg<pos",  4'd13, 32'hFFFFFFFF,   32'd1,          16'h0);
        run_op("R8 slt pos<neg",  4'd13, 32'd1,          32'h80000000,   16'h0);
        run_op("R8 slti vs -1",   4'd14, 32'hFFFFFFFE,   32'd0,          16'hFFFF);
        run_op("R11 reg ignores imm", 4'd0, 32'd7,       32'd8,          16'h7FFF);
        run_op("R11 imm ignores b",   4'd11, 32'd1,      32'hFFFFFFFF,   16'h0002);
        idle_check();
        idle_check();

        for (int i = 0; i < 400; i++) begin
            run_op("R3/R10 random", 4'($urandom), $urandom, $urandom, 16'($urandom));
            if (i % 7 == 0) idle_check();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule